// File: doc/BRIEF.md
# Accumulator Processor Sequencer

This block is a small processor core built around one accumulator. It runs its own program without outside help: it reads a 16-bit word from a shared single-port memory and classifies it. When the word addresses memory indirectly, the core first reads a pointer from memory. It then executes the word and returns for the next one. Program and data share the same 4096-word memory of 16-bit words. The memory sits outside the core and is reached through a 12-bit address, a 16-bit write bus, a write strobe and a 16-bit read bus. The read bus returns data one clock after the address is presented.

An instruction word is laid out as follows. Bits 11:0 hold an address. Bits 14:12 hold an operation code. Bit 15 selects indirect addressing. Operation code 111 marks a word that does not address memory. The core reports such a word with a one-cycle flag and otherwise does nothing with it. All other codes select one of seven memory operations on the accumulator, the program counter or a memory word. A halt input parks the core before its next fetch.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and the accumulator and puts the core in its fetch step. While reset is held and on the first cycle after it, mem_addr is 0 and mem_we is 0.
- R2: A word whose bits 14:12 are 111 is not a memory reference. With bit 15 = 0, regref_seen is high for exactly one cycle, two cycles after that word's fetch cycle. With bit 15 = 1, io_seen behaves the same way. Neither word writes memory or changes the accumulator. The program counter only advances by one.
- R3: With bit 15 = 1, the effective address is bits 11:0 of the memory word at bits 11:0 of the instruction. With bit 15 = 0, the effective address is bits 11:0 of the instruction.
- R4: Codes 000, 001 and 010 set the accumulator to AC AND M[EA], to (AC + M[EA]) modulo 2^16 and to M[EA], respectively.
- R5: Code 011 writes the accumulator to M[EA] and changes nothing else.
- R6: Code 100 sets the program counter to EA. The program counter always counts modulo 4096, so the word after address 4095 is fetched from address 0.
- R7: Code 101 writes the address of the following instruction, zero-extended to 16 bits, to M[EA]. It then sets the program counter to (EA + 1) modulo 4096.
- R8: Code 110 writes (M[EA] + 1) modulo 2^16 back to M[EA]. When that value is zero, the program counter advances by one more, which skips the next instruction.
- R9: While halt is high in the fetch step, the core stays in fetch. The program counter holds, mem_addr equals the program counter and no write occurs. Execution resumes when halt falls.
- R10: An instruction takes 3 cycles when it is not a memory reference. Codes 011, 100 and 101 take 4 cycles, codes 000, 001 and 010 take 5 and code 110 takes 6. Indirect addressing adds 2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Hold the core in its fetch step |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 16 | Memory read data, valid one cycle after its address |
| pc_q | output | 12 | Program counter |
| ac_q | output | 16 | Accumulator |
| regref_seen | output | 1 | One-cycle pulse on a register-operation word |
| io_seen | output | 1 | One-cycle pulse on an input-output word |

## Verification
The bench targets the increment-and-skip operation at the 0xFFFF to 0 rollover. A core that tested the value before the increment, or skipped without writing back, would leave the program counter one word off or a counter unchanged. The bench also checks that branch-and-save stores the address after itself and lands one word past the saved slot, including the wrap from 0xFFF to 0; an off-by-one there shows up as a wrong return point. An addition whose carry runs past bit 15 would corrupt the accumulator, and a core that counted its cycles wrongly would drift against the bench's step model during long random programs. The bench also checks that a halt held in fetch freezes the program counter, and that non-memory words raise only their own flag.

// File: rtl/acc_pkg.sv
package acc_pkg;
    localparam int AW   = 12;
    localparam int DW   = 16;
    localparam int OPW  = 3;
    localparam int PADW = DW - AW;

    typedef enum logic [OPW-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_EXT = 3'd7
    } opcode_t;

    typedef enum logic [1:0] {
        CL_MEM = 2'd0,
        CL_REG = 2'd1,
        CL_IO  = 2'd2
    } iclass_t;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_LOADIR = 3'd1,
        PH_DECODE = 3'd2,
        PH_INDRD  = 3'd3,
        PH_INDWB  = 3'd4,
        PH_EXA    = 3'd5,
        PH_EXB    = 3'd6,
        PH_EXC    = 3'd7
    } phase_t;

    typedef struct packed {
        logic          ind;
        opcode_t       op;
        logic [AW-1:0] addr;
    } instr_t;

    function automatic iclass_t classify(input instr_t w);
        if (w.op != OP_EXT) return CL_MEM;
        return w.ind ? CL_IO : CL_REG;
    endfunction

    function automatic logic reads_operand(input opcode_t op);
        return (op == OP_AND) || (op == OP_ADD) || (op == OP_LDA) || (op == OP_ISZ);
    endfunction
endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
(
    input  instr_t        ir,
    output iclass_t       cls,
    output opcode_t       op,
    output logic          ind,
    output logic [AW-1:0] addr
);
    always_comb begin
        cls  = classify(ir);
        op   = ir.op;
        ind  = ir.ind;
        addr = ir.addr;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  opcode_t       op,
    input  logic [DW-1:0] ac,
    input  logic [DW-1:0] rd,
    output logic [DW-1:0] ac_next,
    output logic [DW-1:0] inc_val
);
    always_comb begin
        unique case (op)
            OP_AND:  ac_next = ac & rd;
            OP_ADD:  ac_next = ac + rd;
            OP_LDA:  ac_next = rd;
            default: ac_next = ac;
        endcase
        inc_val = rd + 1'b1;
    end
endmodule

// File: rtl/acc_timer.sv
module acc_timer
    import acc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    halt,
    input  iclass_t cls,
    input  opcode_t op,
    input  logic    ind,
    output phase_t  phase
);
    phase_t nxt;

    always_comb begin
        nxt = PH_FETCH;
        unique case (phase)
            PH_FETCH:  nxt = halt ? PH_FETCH : PH_LOADIR;
            PH_LOADIR: nxt = PH_DECODE;
            PH_DECODE: begin
                if (cls != CL_MEM) nxt = PH_FETCH;
                else if (ind)      nxt = PH_INDRD;
                else               nxt = PH_EXA;
            end
            PH_INDRD:  nxt = PH_INDWB;
            PH_INDWB:  nxt = PH_EXA;
            PH_EXA:    nxt = reads_operand(op) ? PH_EXB : PH_FETCH;
            PH_EXB:    nxt = (op == OP_ISZ) ? PH_EXC : PH_FETCH;
            PH_EXC:    nxt = PH_FETCH;
            default:   nxt = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FETCH;
        else     phase <= nxt;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc_q,
    output logic [DW-1:0] ac_q,
    output logic          regref_seen,
    output logic          io_seen
);
    logic [AW-1:0] pc_r, ar_r;
    logic [DW-1:0] ac_r, dr_r;
    instr_t        ir_r;
    phase_t        phase;
    iclass_t       cls;
    opcode_t       op;
    logic          ind;
    logic [AW-1:0] ir_addr;
    logic [DW-1:0] ac_next, inc_val;

    acc_decode u_dec (
        .ir   (ir_r),
        .cls  (cls),
        .op   (op),
        .ind  (ind),
        .addr (ir_addr)
    );

    acc_alu u_alu (
        .op      (op),
        .ac      (ac_r),
        .rd      (mem_rdata),
        .ac_next (ac_next),
        .inc_val (inc_val)
    );

    acc_timer u_tmr (
        .clk   (clk),
        .rst   (rst),
        .halt  (halt),
        .cls   (cls),
        .op    (op),
        .ind   (ind),
        .phase (phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_r <= '0;
            ac_r <= '0;
            ar_r <= '0;
            dr_r <= '0;
            ir_r <= '0;
        end else begin
            unique case (phase)
                PH_LOADIR: begin
                    ir_r <= instr_t'(mem_rdata);
                    pc_r <= pc_r + 1'b1;
                end
                PH_DECODE: ar_r <= ir_addr;
                PH_INDWB:  ar_r <= mem_rdata[AW-1:0];
                PH_EXA: begin
                    if (op == OP_BUN) pc_r <= ar_r;
                    if (op == OP_BSA) pc_r <= ar_r + 1'b1;
                end
                PH_EXB: begin
                    ac_r <= ac_next;
                    dr_r <= inc_val;
                end
                PH_EXC: if (dr_r == '0) pc_r <= pc_r + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_INDRD, PH_EXA, PH_EXC: mem_addr = ar_r;
            default:                  mem_addr = pc_r;
        endcase
        mem_we    = (phase == PH_EXC) ||
                    ((phase == PH_EXA) && ((op == OP_STA) || (op == OP_BSA)));
        if (phase == PH_EXC)    mem_wdata = dr_r;
        else if (op == OP_BSA)  mem_wdata = {{PADW{1'b0}}, pc_r};
        else                    mem_wdata = ac_r;
    end

    assign pc_q        = pc_r;
    assign ac_q        = ac_r;
    assign regref_seen = (phase == PH_DECODE) && (cls == CL_REG);
    assign io_seen     = (phase == PH_DECODE) && (cls == CL_IO);
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          halt,
    input phase_t        phase,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_we,
    input logic [DW-1:0] mem_rdata,
    input logic [AW-1:0] pc_q,
    input logic [DW-1:0] ac_q,
    input logic [AW-1:0] ar_r,
    input logic          regref_seen,
    input logic          io_seen
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0 && ac_q == '0 && mem_addr == '0 && !mem_we));

    a_r2_flags_apart: assert property (@(posedge clk) disable iff (rst)
        !(regref_seen && io_seen));

    a_r2_flag_pulse: assert property (@(posedge clk) disable iff (rst)
        (regref_seen || io_seen) |=> !(regref_seen || io_seen));

    a_r2_flag_quiet: assert property (@(posedge clk) disable iff (rst)
        (regref_seen || io_seen) |-> !mem_we);

    a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
        (halt && phase == PH_FETCH) |=> (phase == PH_FETCH && pc_q == $past(pc_q)));

    a_r9_fetch_addr: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |-> (mem_addr == pc_q && !mem_we));

    a_r5_write_at_ea: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == ar_r));

    a_r8_isz_increment: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXC) |-> (mem_we && mem_wdata == DW'($past(mem_rdata) + 1'b1)));
endmodule

bind acc_core acc_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .halt        (halt),
    .phase       (phase),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .mem_rdata   (mem_rdata),
    .pc_q        (pc_q),
    .ac_q        (ac_q),
    .ar_r        (ar_r),
    .regref_seen (regref_seen),
    .io_seen     (io_seen)
);

// File: tb/acc_core_bench.sv
`timescale 1ns/1ps
module acc_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt = 1'b0;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [11:0] pc_q;
    logic [15:0] ac_q;
    logic        regref_seen, io_seen;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] dmem [4096];
    logic [15:0] rmem [4096];
    logic [11:0] rpc;
    logic [15:0] rac;

    always #5 clk = ~clk;

    acc_core u_acc_core (
        .clk(clk), .rst(rst), .halt(halt),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .pc_q(pc_q), .ac_q(ac_q),
        .regref_seen(regref_seen), .io_seen(io_seen)
    );

    always @(posedge clk) begin
        if (mem_we) dmem[mem_addr] <= mem_wdata;
        mem_rdata <= dmem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 4096; i++) begin
            dmem[i] = 16'h0;
            rmem[i] = 16'h0;
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        dmem[a] = w;
        rmem[a] = w;
    endtask

    // step model of one instruction, per R3..R8, with cycle cost per R10
    task automatic ref_step(output int cyc);
        logic [15:0] w, v;
        logic [11:0] ea;
        logic [2:0]  op;
        w   = rmem[rpc];
        rpc = rpc + 12'd1;
        op  = w[14:12];
        ea  = w[11:0];
        cyc = 3;
        if (op == 3'd7) return;
        if (w[15]) begin
            ea  = rmem[ea][11:0];
            cyc = cyc + 2;
        end
        case (op)
            3'd0: begin rac = rac & rmem[ea]; cyc += 2; end
            3'd1: begin rac = rac + rmem[ea]; cyc += 2; end
            3'd2: begin rac = rmem[ea];       cyc += 2; end
            3'd3: begin rmem[ea] = rac;       cyc += 1; end
            3'd4: begin rpc = ea;             cyc += 1; end
            3'd5: begin rmem[ea] = {4'h0, rpc}; rpc = ea + 12'd1; cyc += 1; end
            default: begin
                v = rmem[ea] + 16'd1;
                rmem[ea] = v;
                if (v == 16'd0) rpc = rpc + 12'd1;
                cyc += 3;
            end
        endcase
    endtask

    task automatic ref_run(input int n, output int cycles);
        int c;
        rpc = 12'd0;
        rac = 16'd0;
        cycles = 0;
        for (int k = 0; k < n; k++) begin
            ref_step(c);
            cycles += c;
        end
    endtask

    task automatic start_run();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic adv(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cmp_all(input string tag);
        int miss = 0;
        int first = -1;
        chk(pc_q == rpc, tag, "pc", pc_q, rpc);
        chk(ac_q == rac, tag, "ac", ac_q, rac);
        for (int i = 0; i < 4096; i++)
            if (dmem[i] !== rmem[i]) begin
                miss++;
                if (first < 0) first = i;
            end
        chk(miss == 0, tag, "memory mismatches", miss, 0);
        if (first >= 0)
            $display("  first differing word %0h: %0h vs %0h", first, dmem[first], rmem[first]);
    endtask

    initial begin
        int cyc;
        void'($urandom(32'h5eed));
        clear_mem();

        // R1: reset state
        start_run();
        @(negedge clk);
        rst = 1'b1;
        adv(1);
        chk(mem_addr == 12'h0, "R1", "mem_addr in reset", mem_addr, 0);
        chk(!mem_we, "R1", "mem_we in reset", mem_we, 0);
        chk(pc_q == 12'h0 && ac_q == 16'h0, "R1", "pc/ac in reset", {pc_q, ac_q}, 0);

        // R3 R4 R5: load, indirect add with carry loss, and, store
        clear_mem();
        put(0, 16'h2100); put(1, 16'h9101); put(2, 16'h0103); put(3, 16'h3104);
        put(12'h100, 16'hFFF0); put(12'h101, 16'h0102);
        put(12'h102, 16'h0025); put(12'h103, 16'h0F0F);
        ref_run(4, cyc);
        chk(cyc == 21, "R10", "model cycles", cyc, 21);
        start_run();
        adv(5);
        chk(ac_q == 16'hFFF0, "R4", "lda result", ac_q, 16'hFFF0);
        adv(7);
        chk(ac_q == 16'h0015, "R3", "indirect add wraps", ac_q, 16'h0015);
        adv(5);
        chk(ac_q == 16'h0005, "R4", "and result", ac_q, 16'h0005);
        adv(4);
        chk(dmem[12'h104] == 16'h0005, "R5", "stored word", dmem[12'h104], 5);
        chk(pc_q == 12'd4, "R5", "pc after store", pc_q, 4);

        // R6 R7: branch, call, indirect return
        clear_mem();
        put(0, 16'h4010); put(12'h010, 16'h5020); put(12'h021, 16'hC020);
        start_run();
        adv(4);
        chk(pc_q == 12'h010, "R6", "branch target", pc_q, 12'h010);
        adv(4);
        chk(pc_q == 12'h021, "R7", "pc after call", pc_q, 12'h021);
        chk(dmem[12'h020] == 16'h0011, "R7", "saved return", dmem[12'h020], 16'h0011);
        adv(6);
        chk(pc_q == 12'h011, "R6", "indirect return", pc_q, 12'h011);

        // R7: call to last word wraps
        clear_mem();
        put(0, 16'h5FFF);
        start_run();
        adv(4);
        chk(dmem[12'hFFF] == 16'h0001, "R7", "saved at top", dmem[12'hFFF], 1);
        chk(pc_q == 12'h000, "R7", "ea+1 wraps", pc_q, 0);

        // R6: pc wraps past 4095
        clear_mem();
        put(0, 16'h4FFF); put(12'hFFF, 16'h7000);
        start_run();
        adv(7);
        chk(pc_q == 12'h000, "R6", "pc wrap", pc_q, 0);

        // R8: increment and skip
        clear_mem();
        put(0, 16'h6100); put(2, 16'h6101);
        put(12'h100, 16'hFFFF); put(12'h101, 16'h0005);
        start_run();
        adv(6);
        chk(dmem[12'h100] == 16'h0000, "R8", "rollover write", dmem[12'h100], 0);
        chk(pc_q == 12'd2, "R8", "skip taken", pc_q, 2);
        adv(6);
        chk(dmem[12'h101] == 16'h0006, "R8", "plain increment", dmem[12'h101], 6);
        chk(pc_q == 12'd3, "R8", "no skip", pc_q, 3);

        // R2: non-memory words
        clear_mem();
        put(0, 16'h2100); put(1, 16'h7800); put(2, 16'hF400); put(12'h100, 16'h1234);
        ref_run(3, cyc);
        start_run();
        adv(7);
        chk(regref_seen && !io_seen, "R2", "register flag", {regref_seen, io_seen}, 2);
        adv(1);
        chk(!regref_seen && !io_seen, "R2", "flags drop", {regref_seen, io_seen}, 0);
        adv(2);
        chk(!regref_seen && io_seen, "R2", "io flag", {regref_seen, io_seen}, 1);
        adv(1);
        chk(ac_q == 16'h1234 && pc_q == 12'd3, "R2", "ac/pc after nops", {pc_q, ac_q}, {12'd3, 16'h1234});
        cmp_all("R2");

        // R9: halt from reset, then halt at an instruction boundary
        clear_mem();
        put(0, 16'h2100); put(1, 16'h2101);
        put(12'h100, 16'hAAAA); put(12'h101, 16'h5555);
        halt = 1'b1;
        start_run();
        adv(20);
        chk(pc_q == 12'd0 && mem_addr == 12'd0 && !mem_we, "R9", "held at start", pc_q, 0);
        halt = 1'b0;
        adv(5);
        chk(ac_q == 16'hAAAA, "R9", "resumed", ac_q, 16'hAAAA);
        halt = 1'b1;
        adv(10);
        chk(pc_q == 12'd1 && mem_addr == 12'd1, "R9", "held mid-run", pc_q, 1);
        chk(ac_q == 16'hAAAA, "R9", "ac held", ac_q, 16'hAAAA);
        halt = 1'b0;
        adv(5);
        chk(ac_q == 16'h5555, "R9", "second after release", ac_q, 16'h5555);

        // R10 plus R3..R8: random programs against the step model
        for (int t = 0; t < 20; t++) begin
            logic [15:0] w;
            clear_mem();
            for (int a = 0; a < 256; a++) begin
                w = 16'($urandom);
                w[11:8] = 4'h0;
                put(a, w);
            end
            ref_run(150, cyc);
            start_run();
            adv(cyc);
            cmp_all("R10");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule